// File: doc/BRIEF.md
# Floppy Controller Host Command Sequencer

This block is the byte-serial host side of a floppy disk controller. A host sees two byte-wide registers: a read-only status register (selected with `host_sel` low) and a data register (`host_sel` high). Through the data register the host writes a command byte and the parameter bytes that this command needs. The sequencer hands the decoded command to an execution unit over a valid/ready channel. It accepts the execution unit's result over a second valid/ready channel. It then returns the result bytes to the host one per data read and goes back to the idle command phase.

Both host channels are paced by the status register. The host may write a byte only while the request bit (bit 7) is set and the direction bit (bit 6) is clear. It may read a result byte only while both bits are set. The command channel follows valid/ready rules. `cmd_valid` rises one cycle after the last command byte and stays high, with all command fields stable, until a cycle in which `cmd_ready` is high. In the next cycle `res_ready` rises and stays high until a cycle in which `res_valid` is high. The result fields are captured in that cycle. The execution unit may hold off either handshake for any number of cycles.

Top module: `fdc_host_seq`

## Requirements
- R1: After reset the status register reads 0x80 (request only). The first data write after reset is taken as a command byte. Status bits: 7 request, 6 direction (1 = controller to host), 5 non-DMA, 4 busy, 3..0 one busy flag per drive.
- R2: The command code is bits 4:0 of the first byte. The number of parameter bytes that follow depends on the code:
  - 0x08 (sense interrupt): 0
  - 0x07 (recalibrate), 0x04 (sense drive), 0x0A (read ID): 1
  - 0x03 (specify), 0x0F (seek): 2
  - 0x0D (format): 5
  - 0x06 (read), 0x05 (write): 8
- R2 (continued): While a command is partly collected, the status reads 0x90. From the cycle after the last byte until the result is accepted, the status shows busy plus the busy flag of the selected drive, with the request bit clear. Specify and sense interrupt set no drive flag.
- R3: `cmd_code` carries bits 4:0 of the command byte and `cmd_opts` carries bits 7:5. Parameter byte k (k = 0 is the byte after the command byte) appears on `cmd_params[8k+7:8k]`. The drive comes from bits 1:0 of parameter byte 0 and the head from its bit 2, for every command except specify, which leaves the previous drive and head in place.
- R4: `cmd_valid` is held with stable fields until `cmd_ready`. `res_ready` is high from the next cycle until `res_valid`. The two are never high together.
- R5: During the result phase the status reads 0xD0 (request, direction and busy), plus bit 5 when non-DMA mode is set.
- R6: Read, write, read ID and format return seven bytes in this order: ST0, ST1, ST2, C, H, R, N. `res_stat` packs {ST3, ST2, ST1, ST0} with ST0 in bits 7:0, and `res_addr` packs {N, R, H, C} with C in bits 7:0. After N is read the status reads 0x80.
- R7: Sense interrupt returns ST0 then `res_cyl`. Sense drive returns ST3 only. Each phase then ends with the status at 0x80.
- R8: Specify, seek and recalibrate have no result phase. The status returns to 0x80 in the cycle after the result handshake.
- R9: A command code not listed in R2 is not passed to the execution unit. It produces a one-byte result equal to 0x80 | head<<2 | drive, using the last selected head and drive (both 0 after reset).
- R10: A data read during the command phase clears the write-byte index. Any partly collected command is dropped, the status returns to 0x80, and the next data write is a command byte.
- R11: A data write during the result phase is discarded and clears the read-byte index, so the next data read returns the first result byte again.
- R12: Writes to the status register are ignored. Data writes during execution are ignored. A data read outside the result phase returns 0x00.
- R13: Bit 0 of specify's second parameter byte sets the non-DMA flag (status bit 5). The flag shows in every phase until the next specify or reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_sel | input | 1 | 0 selects the status register, 1 selects the data register |
| host_wr | input | 1 | Host write strobe, one byte per cycle |
| host_rd | input | 1 | Host read strobe; a data read advances the result readout |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Status or current result byte, combinational from `host_sel` |
| cmd_valid | output | 1 | Decoded command offered to the execution unit |
| cmd_ready | input | 1 | Execution unit takes the command |
| cmd_code | output | 5 | Command code |
| cmd_opts | output | 3 | Option bits from the top of the command byte |
| cmd_drive | output | 2 | Selected drive |
| cmd_head | output | 1 | Selected head |
| cmd_params | output | 64 | Parameter bytes, byte k at bits 8k+7:8k |
| res_valid | input | 1 | Execution unit presents its result |
| res_ready | output | 1 | Sequencer waits for a result |
| res_stat | input | 32 | {ST3, ST2, ST1, ST0} |
| res_addr | input | 32 | {N, R, H, C} |
| res_cyl | input | 8 | Present cylinder, for sense interrupt |

## Verification
The hardest states to reach are the host strobes that arrive at the wrong time. These are a data read that cuts a command off part-way through its parameters, a data write in the middle of a result readout, and a data write while the execution unit is still holding off its result. The bench reaches them by stretching the handshakes with its own execution-unit model, using programmable delays on both ready and valid. It injects the stray strobe while the status register shows the intermediate phase. It then proves the effect from the ports: the next command is decoded from scratch, the readout starts again at ST0, or the status stays unchanged. Invalid-command results are checked after drive and head have been set by earlier commands, so that the head and drive bits of ST0 are nonzero.

// File: rtl/fdc_seq_pkg.sv
package fdc_seq_pkg;
  parameter int FDC_DW         = 8;
  parameter int FDC_CODE_W     = 5;
  parameter int FDC_NUM_DRV    = 4;
  parameter int FDC_DRV_W      = $clog2(FDC_NUM_DRV);
  parameter int FDC_MAX_PARAMS = 8;
  parameter int FDC_RES_SLOTS  = 7;

  // status register bit positions
  localparam int SB_RQM = 7;
  localparam int SB_DIO = 6;
  localparam int SB_NDM = 5;
  localparam int SB_CB  = 4;

  localparam logic [FDC_CODE_W-1:0] OP_SPECIFY   = 5'h03;
  localparam logic [FDC_CODE_W-1:0] OP_SENSE_DRV = 5'h04;
  localparam logic [FDC_CODE_W-1:0] OP_WRITE     = 5'h05;
  localparam logic [FDC_CODE_W-1:0] OP_READ      = 5'h06;
  localparam logic [FDC_CODE_W-1:0] OP_RECAL     = 5'h07;
  localparam logic [FDC_CODE_W-1:0] OP_SENSE_INT = 5'h08;
  localparam logic [FDC_CODE_W-1:0] OP_READ_ID   = 5'h0A;
  localparam logic [FDC_CODE_W-1:0] OP_FORMAT    = 5'h0D;
  localparam logic [FDC_CODE_W-1:0] OP_SEEK      = 5'h0F;

  typedef enum logic [1:0] {
    PH_CMD,
    PH_ISSUE,
    PH_WAIT,
    PH_RESULT
  } phase_t;

  typedef enum logic [2:0] {
    RK_NONE,
    RK_DRVST,
    RK_INTR,
    RK_FULL,
    RK_BAD
  } rkind_t;

  function automatic int unsigned param_need(input logic [FDC_CODE_W-1:0] c);
    case (c)
      OP_RECAL, OP_SENSE_DRV, OP_READ_ID: return 1;
      OP_SPECIFY, OP_SEEK:                return 2;
      OP_FORMAT:                          return 5;
      OP_READ, OP_WRITE:                  return 8;
      default:                            return 0;
    endcase
  endfunction

  function automatic rkind_t res_kind(input logic [FDC_CODE_W-1:0] c);
    case (c)
      OP_SPECIFY, OP_SEEK, OP_RECAL:             return RK_NONE;
      OP_SENSE_DRV:                              return RK_DRVST;
      OP_SENSE_INT:                              return RK_INTR;
      OP_READ, OP_WRITE, OP_READ_ID, OP_FORMAT:  return RK_FULL;
      default:                                   return RK_BAD;
    endcase
  endfunction

  function automatic logic uses_drive(input logic [FDC_CODE_W-1:0] c);
    return (c != OP_SPECIFY) && (c != OP_SENSE_INT);
  endfunction
endpackage

// File: rtl/fdc_cmd_collect.sv
module fdc_cmd_collect
  import fdc_seq_pkg::*;
#(
  parameter int DW     = FDC_DW,
  parameter int MAXP   = FDC_MAX_PARAMS,
  parameter int DRV_W  = FDC_DRV_W,
  parameter int CODE_W = FDC_CODE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               byte_wr,
  input  logic               abort,
  input  logic [DW-1:0]      wdata,
  output logic               done,
  output logic               bad,
  output logic               busy,
  output logic [DW-1:0]      cmd_byte,
  output logic [MAXP*DW-1:0] params,
  output logic [DRV_W-1:0]   drive,
  output logic               head,
  output logic               ndma
);
  localparam int IDX_W = $clog2(MAXP + 1);

  logic [IDX_W-1:0]  idx_q;
  logic [DW-1:0]     par_q [MAXP];
  logic [CODE_W-1:0] code_now;
  logic              last_byte;

  // the code in force: from the incoming byte while it is the first one
  assign code_now  = (idx_q == '0) ? wdata[CODE_W-1:0] : cmd_byte[CODE_W-1:0];
  assign last_byte = (idx_q == IDX_W'(param_need(code_now)));
  assign done      = byte_wr && last_byte;
  assign bad       = done && (idx_q == '0) && (res_kind(code_now) == RK_BAD);
  assign busy      = (idx_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q    <= '0;
      cmd_byte <= '0;
      drive    <= '0;
      head     <= 1'b0;
      ndma     <= 1'b0;
      for (int k = 0; k < MAXP; k++) par_q[k] <= '0;
    end else if (abort) begin
      idx_q <= '0;
    end else if (byte_wr) begin
      if (idx_q == '0) cmd_byte <= wdata;
      for (int k = 0; k < MAXP; k++) begin
        if (idx_q == IDX_W'(k + 1)) par_q[k] <= wdata;
      end
      if ((idx_q == IDX_W'(1)) && (code_now != OP_SPECIFY)) begin
        drive <= wdata[DRV_W-1:0];
        head  <= wdata[DRV_W];
      end
      if ((idx_q == IDX_W'(2)) && (code_now == OP_SPECIFY)) ndma <= wdata[0];
      idx_q <= last_byte ? '0 : idx_q + 1'b1;
    end
  end

  for (genvar g = 0; g < MAXP; g++) begin : g_pack
    assign params[g*DW +: DW] = par_q[g];
  end
endmodule

// File: rtl/fdc_result_seq.sv
module fdc_result_seq
  import fdc_seq_pkg::*;
#(
  parameter int DW    = FDC_DW,
  parameter int SLOTS = FDC_RES_SLOTS
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  rkind_t          kind,
  input  logic [4*DW-1:0] stat,
  input  logic [4*DW-1:0] addr,
  input  logic [DW-1:0]   cyl,
  input  logic [DW-1:0]   bad_st0,
  input  logic            step,
  input  logic            rewind,
  output logic [DW-1:0]   cur,
  output logic            last
);
  localparam int PTR_W = $clog2(SLOTS);

  logic [DW-1:0]    slot_q [SLOTS];
  logic [DW-1:0]    slot_d [SLOTS];
  logic [PTR_W-1:0] ptr_q;
  logic [PTR_W-1:0] end_q;
  logic [PTR_W-1:0] end_d;

  // result shape chosen by command kind (the full shape needs SLOTS >= 7)
  always_comb begin
    for (int k = 0; k < SLOTS; k++) slot_d[k] = '0;
    end_d = '0;
    case (kind)
      RK_FULL: begin
        slot_d[0] = stat[0*DW +: DW];
        slot_d[1] = stat[1*DW +: DW];
        slot_d[2] = stat[2*DW +: DW];
        slot_d[3] = addr[0*DW +: DW];
        slot_d[4] = addr[1*DW +: DW];
        slot_d[5] = addr[2*DW +: DW];
        slot_d[6] = addr[3*DW +: DW];
        end_d     = PTR_W'(6);
      end
      RK_INTR: begin
        slot_d[0] = stat[0*DW +: DW];
        slot_d[1] = cyl;
        end_d     = PTR_W'(1);
      end
      RK_DRVST: slot_d[0] = stat[3*DW +: DW];
      RK_BAD:   slot_d[0] = bad_st0;
      default:  end_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      end_q <= '0;
      for (int k = 0; k < SLOTS; k++) slot_q[k] <= '0;
    end else if (load) begin
      ptr_q <= '0;
      end_q <= end_d;
      for (int k = 0; k < SLOTS; k++) slot_q[k] <= slot_d[k];
    end else if (rewind) begin
      ptr_q <= '0;
    end else if (step) begin
      ptr_q <= (ptr_q == end_q) ? '0 : ptr_q + 1'b1;
    end
  end

  assign cur  = slot_q[ptr_q];
  assign last = (ptr_q == end_q);
endmodule

// File: rtl/fdc_status_gen.sv
module fdc_status_gen
  import fdc_seq_pkg::*;
#(
  parameter int DW    = FDC_DW,
  parameter int NDRV  = FDC_NUM_DRV,
  parameter int DRV_W = FDC_DRV_W
) (
  input  phase_t           phase,
  input  logic             collecting,
  input  logic             ndma,
  input  logic             drv_flag,
  input  logic [DRV_W-1:0] drive,
  output logic [DW-1:0]    status
);
  always_comb begin
    status         = '0;
    status[SB_NDM] = ndma;
    case (phase)
      PH_CMD: begin
        status[SB_RQM] = 1'b1;
        status[SB_CB]  = collecting;
      end
      PH_ISSUE, PH_WAIT: begin
        status[SB_CB] = 1'b1;
        for (int k = 0; k < NDRV; k++) begin
          if (drv_flag && (drive == DRV_W'(k))) status[k] = 1'b1;
        end
      end
      default: begin
        status[SB_RQM] = 1'b1;
        status[SB_DIO] = 1'b1;
        status[SB_CB]  = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/fdc_host_seq.sv
module fdc_host_seq
  import fdc_seq_pkg::*;
#(
  parameter int DW     = FDC_DW,
  parameter int CODE_W = FDC_CODE_W,
  parameter int DRV_W  = FDC_DRV_W,
  parameter int MAXP   = FDC_MAX_PARAMS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_sel,
  input  logic               host_wr,
  input  logic               host_rd,
  input  logic [DW-1:0]      host_wdata,
  output logic [DW-1:0]      host_rdata,
  output logic               cmd_valid,
  input  logic               cmd_ready,
  output logic [CODE_W-1:0]  cmd_code,
  output logic [DW-CODE_W-1:0] cmd_opts,
  output logic [DRV_W-1:0]   cmd_drive,
  output logic               cmd_head,
  output logic [MAXP*DW-1:0] cmd_params,
  input  logic               res_valid,
  output logic               res_ready,
  input  logic [4*DW-1:0]    res_stat,
  input  logic [4*DW-1:0]    res_addr,
  input  logic [DW-1:0]      res_cyl
);
  phase_t          phase_q, phase_d;
  logic            d_wr, d_rd;
  logic            col_done, col_bad, col_busy, col_ndma, col_head;
  logic [DW-1:0]   col_cmd;
  logic [DRV_W-1:0] col_drive;
  logic            res_load, res_last;
  rkind_t          load_kind;
  logic [DW-1:0]   res_cur, bad_st0, status;

  // a data read wins over a simultaneous data write
  assign d_rd = host_sel && host_rd;
  assign d_wr = host_sel && host_wr && !host_rd;

  fdc_cmd_collect #(.DW(DW), .MAXP(MAXP), .DRV_W(DRV_W), .CODE_W(CODE_W)) u_collect (
    .clk     (clk),
    .rst_n   (rst_n),
    .byte_wr (d_wr && (phase_q == PH_CMD)),
    .abort   (d_rd && (phase_q == PH_CMD)),
    .wdata   (host_wdata),
    .done    (col_done),
    .bad     (col_bad),
    .busy    (col_busy),
    .cmd_byte(col_cmd),
    .params  (cmd_params),
    .drive   (col_drive),
    .head    (col_head),
    .ndma    (col_ndma)
  );

  assign cmd_code  = col_cmd[CODE_W-1:0];
  assign cmd_opts  = col_cmd[DW-1:CODE_W];
  assign cmd_drive = col_drive;
  assign cmd_head  = col_head;

  assign bad_st0   = DW'(8'h80) | (DW'(col_head) << DRV_W) | DW'(col_drive);
  assign load_kind = (phase_q == PH_CMD) ? RK_BAD : res_kind(cmd_code);
  assign res_load  = ((phase_q == PH_CMD) && col_bad) ||
                     ((phase_q == PH_WAIT) && res_valid && (res_kind(cmd_code) != RK_NONE));

  fdc_result_seq #(.DW(DW)) u_result (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (res_load),
    .kind   (load_kind),
    .stat   (res_stat),
    .addr   (res_addr),
    .cyl    (res_cyl),
    .bad_st0(bad_st0),
    .step   (d_rd && (phase_q == PH_RESULT)),
    .rewind (d_wr && (phase_q == PH_RESULT)),
    .cur    (res_cur),
    .last   (res_last)
  );

  always_comb begin
    phase_d = phase_q;
    case (phase_q)
      PH_CMD:    if (col_done) phase_d = col_bad ? PH_RESULT : PH_ISSUE;
      PH_ISSUE:  if (cmd_ready) phase_d = PH_WAIT;
      PH_WAIT:   if (res_valid) phase_d = (res_kind(cmd_code) == RK_NONE) ? PH_CMD : PH_RESULT;
      default:   if (d_rd && res_last) phase_d = PH_CMD;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_CMD;
    else        phase_q <= phase_d;
  end

  fdc_status_gen #(.DW(DW), .DRV_W(DRV_W)) u_status (
    .phase     (phase_q),
    .collecting(col_busy),
    .ndma      (col_ndma),
    .drv_flag  (uses_drive(cmd_code)),
    .drive     (col_drive),
    .status    (status)
  );

  assign cmd_valid  = (phase_q == PH_ISSUE);
  assign res_ready  = (phase_q == PH_WAIT);
  assign host_rdata = host_sel ? ((phase_q == PH_RESULT) ? res_cur : '0) : status;
endmodule

// File: rtl/fdc_host_seq_chk.sv
module fdc_host_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        host_sel,
  input logic [7:0]  host_rdata,
  input logic        cmd_valid,
  input logic        cmd_ready,
  input logic [4:0]  cmd_code,
  input logic [1:0]  cmd_drive,
  input logic [63:0] cmd_params,
  input logic        res_valid,
  input logic        res_ready
);
  a_r4_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_code) &&
                                   $stable(cmd_drive) && $stable(cmd_params)));

  a_r4_wait_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> res_ready);

  a_r4_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !res_ready);

  a_r6_res_once: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_ready) |=> !res_ready);

  a_r2_exec_status: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_sel && (cmd_valid || res_ready)) |-> (!host_rdata[7] && host_rdata[4]));

  a_r5_dir_status: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_sel && host_rdata[6]) |-> (host_rdata[7] && host_rdata[4]));

  a_r2_drive_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    !host_sel |-> $onehot0(host_rdata[3:0]));
endmodule

bind fdc_host_seq fdc_host_seq_chk chk_i (.*);

// File: tb/fdc_host_seq_tb.sv
`timescale 1ns/1ps
module fdc_host_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        host_sel, host_wr, host_rd;
  logic [7:0]  host_wdata, host_rdata;
  logic        cmd_valid, cmd_ready;
  logic [4:0]  cmd_code;
  logic [2:0]  cmd_opts;
  logic [1:0]  cmd_drive;
  logic        cmd_head;
  logic [63:0] cmd_params;
  logic        res_valid, res_ready;
  logic [31:0] res_stat, res_addr;
  logic [7:0]  res_cyl;

  always #10 clk = ~clk;

  fdc_host_seq dut_i (.*);

  int total = 0;
  int n_bad = 0;
  int rdy_dly = 0;
  int res_dly = 0;
  int c_cnt = 0;
  int r_cnt = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int          mph;          // 0 cmd, 1 issue, 2 wait, 3 result
  int          widx;
  logic [7:0]  mbytes [9];
  int          mdrv, mhd, mnd;
  logic [7:0]  mq[$];
  int          mptr;

  function automatic int m_need(input logic [4:0] c);
    case (c)
      5'h08: return 0;
      5'h07, 5'h04, 5'h0A: return 1;
      5'h03, 5'h0F: return 2;
      5'h0D: return 5;
      5'h05, 5'h06: return 8;
      default: return -1;
    endcase
  endfunction

  function automatic logic [7:0] m_status();
    logic [7:0] s;
    s = 8'(mnd) << 5;
    case (mph)
      0: s = s | 8'h80 | ((widx > 0) ? 8'h10 : 8'h00);
      1, 2: begin
        s = s | 8'h10;
        if (mbytes[0][4:0] != 5'h03 && mbytes[0][4:0] != 5'h08) s = s | (8'h01 << mdrv);
      end
      default: s = s | 8'hD0;
    endcase
    return s;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mph = 0; widx = 0; mdrv = 0; mhd = 0; mnd = 0; mptr = 0; mq = {};
    end else begin
      case (mph)
        0: begin
          if (host_sel && host_rd) widx = 0;
          else if (host_sel && host_wr) begin
            if (widx == 0) begin
              mbytes[0] = host_wdata;
              if (m_need(host_wdata[4:0]) < 0) begin
                mq = {8'h80 | 8'(mhd << 2) | 8'(mdrv)};
                mptr = 0; mph = 3;
              end else if (m_need(host_wdata[4:0]) == 0) mph = 1;
              else widx = 1;
            end else begin
              mbytes[widx] = host_wdata;
              if (widx == 1 && mbytes[0][4:0] != 5'h03) begin
                mdrv = int'(host_wdata[1:0]); mhd = int'(host_wdata[2]);
              end
              if (widx == 2 && mbytes[0][4:0] == 5'h03) mnd = int'(host_wdata[0]);
              if (widx == m_need(mbytes[0][4:0])) begin widx = 0; mph = 1; end
              else widx++;
            end
          end
        end
        1: if (cmd_ready) mph = 2;
        2: if (res_valid) begin
          case (mbytes[0][4:0])
            5'h04: mq = {res_stat[31:24]};
            5'h08: mq = {res_stat[7:0], res_cyl};
            5'h05, 5'h06, 5'h0A, 5'h0D:
              mq = {res_stat[7:0], res_stat[15:8], res_stat[23:16], res_addr[7:0],
                    res_addr[15:8], res_addr[23:16], res_addr[31:24]};
            default: mq = {};
          endcase
          mptr = 0;
          mph = (mq.size() == 0) ? 0 : 3;
        end
        default: begin
          if (host_sel && host_rd) begin
            mptr++;
            if (mptr >= mq.size()) mph = 0;
          end else if (host_sel && host_wr) mptr = 0;
        end
      endcase
    end
  end

  // every-cycle comparison against the model
  always @(posedge clk) begin
    #5;
    if (rst_n) begin
      if (!host_sel)
        chk((mph == 3) ? "R5 status" : (mph == 0 && widx == 0) ? "R1 status" : "R2 status",
            64'(host_rdata), 64'(m_status()));
      chk("R4 cmd_valid", 64'(cmd_valid), 64'(mph == 1));
      chk("R4 res_ready", 64'(res_ready), 64'(mph == 2));
      if (mph == 1) begin
        chk("R3 code", 64'(cmd_code), 64'(mbytes[0][4:0]));
        chk("R3 opts", 64'(cmd_opts), 64'(mbytes[0][7:5]));
        if (mbytes[0][4:0] != 5'h03 && mbytes[0][4:0] != 5'h08) begin
          chk("R3 drive", 64'(cmd_drive), 64'(mdrv));
          chk("R3 head", 64'(cmd_head), 64'(mhd));
        end
        for (int k = 0; k < 8; k++)
          if (k < m_need(mbytes[0][4:0]))
            chk("R3 param", 64'(cmd_params[8*k +: 8]), 64'(mbytes[k+1]));
      end
    end
  end

  // execution-unit stand-in with programmable handshake delays
  always @(negedge clk) begin
    if (!rst_n) begin
      cmd_ready = 1'b0; res_valid = 1'b0; c_cnt = 0; r_cnt = 0;
    end else begin
      if (cmd_ready) cmd_ready = 1'b0;
      else if (cmd_valid) begin
        if (c_cnt >= rdy_dly) begin cmd_ready = 1'b1; c_cnt = 0; end
        else c_cnt++;
      end
      if (res_valid) res_valid = 1'b0;
      else if (res_ready) begin
        if (r_cnt >= res_dly) begin res_valid = 1'b1; r_cnt = 0; end
        else r_cnt++;
      end
    end
  end

  // ---------------- host tasks ----------------
  task automatic wr_data(input logic [7:0] b);
    @(negedge clk);
    host_sel = 1'b1; host_wr = 1'b1; host_wdata = b;
    @(negedge clk);
    host_wr = 1'b0; host_sel = 1'b0;
  endtask

  task automatic wr_stat(input logic [7:0] b);
    @(negedge clk);
    host_sel = 1'b0; host_wr = 1'b1; host_wdata = b;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd_data(input string tag, input logic [7:0] exp);
    @(negedge clk);
    host_sel = 1'b1; host_rd = 1'b1;
    #5 chk(tag, 64'(host_rdata), 64'(exp));
    @(negedge clk);
    host_rd = 1'b0; host_sel = 1'b0;
  endtask

  task automatic rd_stat(input string tag, input logic [7:0] exp);
    @(negedge clk);
    #5 chk(tag, 64'(host_rdata), 64'(exp));
  endtask

  task automatic wait_rqm();
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      #1;
      if (host_rdata[7]) break;
    end
  endtask

  task automatic rd_full(input string tag, input logic [31:0] st, input logic [31:0] ad);
    rd_data(tag, st[7:0]);   rd_data(tag, st[15:8]); rd_data(tag, st[23:16]);
    rd_data(tag, ad[7:0]);   rd_data(tag, ad[15:8]);
    rd_data(tag, ad[23:16]); rd_data(tag, ad[31:24]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++; total++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; host_sel = 1'b0; host_wr = 1'b0; host_rd = 1'b0; host_wdata = 8'h00;
    res_stat = 32'h56341246; res_addr = 32'h02060111; res_cyl = 8'h28;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd_stat("R1 reset", 8'h80);
    rd_data("R12 read idle", 8'h00);

    // R2 R3 R6 read with options, drive 2 head 1
    wr_data(8'h46);
    rd_stat("R2 collecting", 8'h90);
    wr_data(8'h06); wr_data(8'h11); wr_data(8'h01); wr_data(8'h05);
    wr_data(8'h02); wr_data(8'h1A); wr_data(8'h1B);
    rd_stat("R2 before last", 8'h90);
    wr_data(8'hFF);
    wait_rqm();
    rd_stat("R5 result", 8'hD0);
    rd_full("R6 read order", res_stat, res_addr);
    rd_stat("R6 end", 8'h80);

    // R4 write with stretched handshakes
    rdy_dly = 3; res_dly = 4;
    res_stat = 32'h00A1B2C3; res_addr = 32'h01091100;
    wr_data(8'hC5); wr_data(8'h01);
    for (int k = 0; k < 7; k++) wr_data(8'(8'h20 + k));
    rd_stat("R2 exec drive1", 8'h12);
    wait_rqm();
    rd_full("R6 write order", res_stat, res_addr);

    // format (5 params) and read ID (1 param)
    rdy_dly = 0; res_dly = 1;
    res_stat = 32'h11223344; res_addr = 32'h03020100;
    wr_data(8'h4D); wr_data(8'h03); wr_data(8'h02); wr_data(8'h1A); wr_data(8'h36); wr_data(8'hE5);
    wait_rqm();
    rd_full("R6 format order", res_stat, res_addr);
    wr_data(8'h4A); wr_data(8'h00);
    wait_rqm();
    rd_full("R6 read-id order", res_stat, res_addr);

    // R7 sense drive
    res_stat = 32'h79000000;
    wr_data(8'h04); wr_data(8'h05);
    wait_rqm();
    rd_data("R7 sense drive", 8'h79);
    rd_stat("R7 sense drive end", 8'h80);

    // R8 seek and recalibrate
    wr_data(8'h0F); wr_data(8'h02); wr_data(8'h28);
    wait_rqm();
    rd_stat("R8 seek no result", 8'h80);
    rd_data("R8 seek nothing to read", 8'h00);
    wr_data(8'h07); wr_data(8'h03);
    wait_rqm();
    rd_stat("R8 recal no result", 8'h80);

    // R7 sense interrupt
    res_stat = 32'h00000023; res_cyl = 8'h28;
    wr_data(8'h08);
    wait_rqm();
    rd_data("R7 sense int st0", 8'h23);
    rd_data("R7 sense int cyl", 8'h28);
    rd_stat("R7 sense int end", 8'h80);

    // R13 specify keeps drive 3 head 0, sets non-DMA
    wr_data(8'h03); wr_data(8'hDF); wr_data(8'h03);
    wait_rqm();
    rd_stat("R13 ndma idle", 8'hA0);
    // R9 invalid with drive 3 head 0
    wr_data(8'h1F);
    rd_stat("R13 ndma result", 8'hF0);
    rd_data("R9 invalid st0", 8'h83);
    wr_data(8'h03); wr_data(8'hDF); wr_data(8'h02);
    wait_rqm();
    rd_stat("R13 ndma cleared", 8'h80);
    res_stat = 32'h4C000000;
    wr_data(8'h04); wr_data(8'h06);
    wait_rqm();
    rd_data("R7 sense drive 2", 8'h4C);
    wr_data(8'h00);
    rd_data("R9 invalid st0 head1", 8'h86);
    rd_stat("R9 invalid end", 8'h80);

    // R10 read aborts partial command
    wr_data(8'h06); wr_data(8'h01);
    rd_stat("R10 partial", 8'h90);
    rd_data("R10 abort read", 8'h00);
    rd_stat("R10 aborted", 8'h80);
    res_stat = 32'h00000031; res_cyl = 8'h07;
    wr_data(8'h08);
    wait_rqm();
    rd_data("R10 fresh command st0", 8'h31);
    rd_data("R10 fresh command cyl", 8'h07);

    // R11 write during result rewinds
    res_stat = 32'h0055AA01; res_addr = 32'h0302_0104;
    wr_data(8'h06);
    for (int k = 0; k < 8; k++) wr_data(8'(k + 1));
    wait_rqm();
    rd_data("R11 first", 8'h01); rd_data("R11 second", 8'hAA); rd_data("R11 third", 8'h55);
    wr_data(8'h55);
    rd_stat("R11 still result", 8'hD0);
    rd_full("R11 rewound order", res_stat, res_addr);

    // R12 status writes and writes during execution are ignored
    wr_stat(8'h08);
    rd_stat("R12 status write", 8'h80);
    res_dly = 20;
    wr_data(8'h0F); wr_data(8'h01); wr_data(8'h05);
    wr_data(8'h08); wr_data(8'h06);
    rd_stat("R12 exec write ignored", 8'h12);
    rd_data("R12 exec read zero", 8'h00);
    wait_rqm();
    rd_stat("R12 after exec", 8'h80);
    res_dly = 0;
    res_stat = 32'h00000044; res_cyl = 8'h05;
    wr_data(8'h08);
    wait_rqm();
    rd_data("R12 clean follow-up", 8'h44);
    rd_data("R12 clean follow-up cyl", 8'h05);

    repeat (4) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, n_bad);
    $finish;
  end
endmodule